// File: doc/BRIEF.md
# Power-of-Two Gated Clock Prescaler

This block takes the clock of an oscillator core and divides it by a power of two chosen by a 4-bit prescaler code. The result goes to a single clock output. The output can be gated by an output-enable pin, and a power-down pin stops the oscillator path. A start-up counter holds the output quiet until the oscillator has settled. A deglitch filter makes sure that only a sustained power-down request is acted on. All gating decisions are taken while the divided clock is low, so every high pulse that leaves the block has full width.

The block models the oscillator core at twice the master frequency. `clk` is that core clock, and one master cycle is two `clk` cycles. For exponent x, the output period is therefore 2^(x+1) `clk` cycles, which is 2^x master cycles. A divide-by-one setting gives a 50 % square wave at the master rate. When `pwr_pin` is low and the filter has accepted the request, the divider counter is frozen, which stands in for the stopped oscillator.

`pad_oe` feeds the enable of an external tristate pad. `ready` reports that start-up has finished and that no power-down is in progress.

Top module: `gated_pow2_prescaler`

## Requirements
- R1: For a prescaler code x in 0..8, `clk_out` has a period of 2^(x+1) clk cycles and a high phase of 2^x cycles.
- R2: A prescaler code above 8 (for example 9 or 15) gives the same waveform as code 8: period 512, high 256.
- R3: After reset is released, `ready` rises on the 1024th rising clock edge (512 master cycles). Before that, `clk_out` stays low. The same 1024-cycle count applies after power-down ends.
- R4: While `oe_pin` is low, `clk_out` stays low after the current pulse ends. Meanwhile `ready` and `pad_oe` stay high. When `oe_pin` returns high, the output resumes at the same ratio.
- R5: Every high pulse on `clk_out` lasts exactly 2^x cycles, where x is the exponent in force during that pulse. This includes the first pulse after the output is re-enabled and the first pulse after the prescaler code changes.
- R6: The block enters power-down only after `pwr_pin` has been low, after its two-flop synchroniser, for DEGLITCH_CYCLES (default 16) consecutive cycles. Entering power-down drops `ready`, lets any pulse in progress finish, and then holds `clk_out` low. A low pulse of 12 cycles changes neither `ready` nor the output period.
- R7: In power-down, `pad_oe` equals `drive_low`: 1 means the pad is driven low, 0 means the pad is high-Z. In every other state, `pad_oe` is 1.
- R8: With `oe_pin` high, `pwr_pin` rises just after a clock edge while the block is powered down. The first high sample of `clk_out` then follows rising edge number 3 + 1024 + m, counted from that pin change, where m = 3 for x = 0 and m = 2^x for x ≥ 1.
- R9: A new prescaler code takes effect at the end of the output period in progress. When the code is changed during the first high cycle of a period, the next full period already has the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator core clock (twice the master rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_code | input | 4 | Prescaler exponent code; values above 8 are clamped |
| oe_pin | input | 1 | Output enable, active high, asynchronous |
| pwr_pin | input | 1 | High = run, low = power-down request, asynchronous |
| drive_low | input | 1 | Idle level in power-down: 1 = driven low, 0 = high-Z |
| clk_out | output | 1 | Gated, divided clock |
| pad_oe | output | 1 | Drive enable for the output pad |
| ready | output | 1 | Start-up complete and not powering down |

## Verification
Two events can land on the same clock edge. One is the divider wrapping to a new period, at the moment a new prescaler code is loaded. The other is the gate closing, either because the output enable fell or because a power-down request was accepted. The bench provokes this by changing the code in the first high cycle of a period. It also removes the enable and asserts power-down while pulses are in flight. The pulse-width property in the checker then confirms that no high pulse is shortened and that the ratio of each following period matches the new code.

// File: rtl/pgp_pkg.sv
`timescale 1ns/1ps
package pgp_pkg;
  // Control sequence of the output path.
  typedef enum logic [1:0] {
    ST_WARM  = 2'd0,  // start-up hold-off counting
    ST_RUN   = 2'd1,  // output may be gated on
    ST_DRAIN = 2'd2,  // waiting for the last pulse to finish
    ST_OFF   = 2'd3   // oscillator path frozen
  } pgp_state_e;
endpackage

// File: rtl/pgp_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser for a bundle of independent asynchronous pins.
module pgp_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pgp_pd_filter.sv
`timescale 1ns/1ps
// Accepts a power-down request only after it has persisted for DG cycles.
module pgp_pd_filter #(
  parameter int DG = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_s,
  output logic pd_req
);
  localparam int CW = $clog2(DG + 1);
  localparam logic [CW-1:0] DG_C = CW'(DG);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_q <= '0;
    else if (pwr_s)          low_q <= '0;
    else if (low_q != DG_C)  low_q <= low_q + 1'b1;
  end

  assign pd_req = (low_q == DG_C);
endmodule

// File: rtl/pgp_divider.sv
`timescale 1ns/1ps
// Power-of-two divider. A new exponent is loaded only on a period boundary
// or while halted, and the count restarts from zero each time.
module pgp_divider #(
  parameter int MAX_EXP = 8,
  parameter int CODE_W  = 4,
  localparam int EW     = $clog2(MAX_EXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              div_next,
  output logic [EW-1:0]     exp_cur
);
  localparam int CW = MAX_EXP + 1;

  logic [CW-1:0] cnt_q, cnt_nx, lim;
  logic [EW-1:0] exp_q, exp_nx, exp_req;
  logic          at_end;

  always_comb begin
    if (code > CODE_W'(MAX_EXP)) exp_req = EW'(MAX_EXP);
    else                         exp_req = EW'(code);
  end

  assign lim    = CW'((32'd2 << exp_q) - 32'd1);
  assign at_end = (cnt_q == lim);

  always_comb begin
    if (!run || at_end) begin
      cnt_nx = '0;
      exp_nx = exp_req;
    end else begin
      cnt_nx = cnt_q + 1'b1;
      exp_nx = exp_q;
    end
  end

  assign div_next = cnt_nx[exp_nx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      exp_q <= exp_nx;
    end
  end

  assign exp_cur = exp_q;
endmodule

// File: rtl/pgp_gate.sv
`timescale 1ns/1ps
// Output gate: the enable is sampled only while the divided clock is low,
// so a high pulse is either passed whole or suppressed whole.
module pgp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic div_next,
  input  logic en,
  output logic clk_out,
  output logic gate_open
);
  logic gate_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!div_next) gate_q <= en;
      out_q <= div_next & gate_q;
    end
  end

  assign clk_out   = out_q;
  assign gate_open = gate_q;
endmodule

// File: rtl/gated_pow2_prescaler.sv
`timescale 1ns/1ps
module gated_pow2_prescaler
  import pgp_pkg::*;
#(
  parameter int MAX_EXP         = 8,
  parameter int CODE_W          = 4,
  parameter int START_CYCLES    = 512,
  parameter int DEGLITCH_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] presc_code,
  input  logic              oe_pin,
  input  logic              pwr_pin,
  input  logic              drive_low,
  output logic              clk_out,
  output logic              pad_oe,
  output logic              ready
);
  localparam int EW       = $clog2(MAX_EXP + 1);
  localparam int WARM_LEN = 2 * START_CYCLES;  // core cycles per start-up
  localparam int WW       = $clog2(WARM_LEN + 1);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARM_LEN - 1);

  logic [1:0]    pins_s;
  logic          oe_s, pwr_s, pd_req, run, en, div_next, gate_open;
  logic [EW-1:0] exp_cur;
  logic [WW-1:0] warm_cnt;
  pgp_state_e    state;

  // pwr resets to "run" so that reset release is not taken as a request.
  pgp_sync #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pwr_pin, oe_pin}), .q(pins_s)
  );
  assign oe_s  = pins_s[0];
  assign pwr_s = pins_s[1];

  pgp_pd_filter #(.DG(DEGLITCH_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .pwr_s(pwr_s), .pd_req(pd_req)
  );

  assign run = (state != ST_OFF);

  pgp_divider #(.MAX_EXP(MAX_EXP), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .code(presc_code),
    .div_next(div_next), .exp_cur(exp_cur)
  );

  assign ready = (state == ST_RUN);
  assign en    = oe_s & ready;

  pgp_gate u_gate (
    .clk(clk), .rst_n(rst_n), .div_next(div_next), .en(en),
    .clk_out(clk_out), .gate_open(gate_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_WARM;
      warm_cnt <= '0;
    end else begin
      case (state)
        ST_WARM: begin
          if (pd_req)                     state <= ST_DRAIN;
          else if (warm_cnt == WARM_LAST) state <= ST_RUN;
          else                            warm_cnt <= warm_cnt + 1'b1;
        end
        ST_RUN:   if (pd_req) state <= ST_DRAIN;
        ST_DRAIN: if (!gate_open && !clk_out) state <= ST_OFF;
        ST_OFF: begin
          if (pwr_s) begin
            state    <= ST_WARM;
            warm_cnt <= '0;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign pad_oe = run | drive_low;
endmodule

// File: rtl/pgp_checker.sv
`timescale 1ns/1ps
module pgp_checker
  import pgp_pkg::*;
#(
  parameter int MAX_EXP         = 8,
  parameter int START_CYCLES    = 512,
  parameter int DEGLITCH_CYCLES = 16,
  localparam int EW             = $clog2(MAX_EXP + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_pin,
  input logic          clk_out,
  input logic          ready,
  input pgp_state_e    state,
  input logic [EW-1:0] exp_cur
);
  localparam int HW = MAX_EXP + 2;
  localparam int UW = $clog2(2 * START_CYCLES + 1) + 1;
  localparam int LW = $clog2(DEGLITCH_CYCLES + 1) + 1;

  logic [HW-1:0] hi_len;
  logic [UW-1:0] up_cnt;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= '0;
      up_cnt  <= '0;
      low_cnt <= '0;
    end else begin
      hi_len <= clk_out ? hi_len + 1'b1 : '0;
      if (state == ST_OFF)  up_cnt <= '0;
      else if (up_cnt != '1) up_cnt <= up_cnt + 1'b1;
      if (pwr_pin)            low_cnt <= '0;
      else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R5: each high pulse lasts 2^x cycles for the exponent in force
  a_r5_full_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> (hi_len == (HW'(1) << $past(exp_cur))));

  // R3: ready rises exactly after the start-up count
  a_r3_warm_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (up_cnt == UW'(2 * START_CYCLES)));

  // R6: ready drops only after a sustained low on the power pin
  a_r6_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (low_cnt >= LW'(DEGLITCH_CYCLES)));

  // R6: frozen path emits nothing
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> !clk_out);

  // R4: a pulse can only start after the gate was opened in the ready state
  a_r4_rise_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(ready, 2));

  // R2: exponent in force never exceeds the clamp value
  a_r2_exp_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    exp_cur <= EW'(MAX_EXP));
endmodule

bind gated_pow2_prescaler pgp_checker #(
  .MAX_EXP(MAX_EXP), .START_CYCLES(START_CYCLES), .DEGLITCH_CYCLES(DEGLITCH_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .clk_out(clk_out),
  .ready(ready), .state(state), .exp_cur(exp_cur)
);

// File: tb/sim_gated_pow2_prescaler.sv
`timescale 1ns/1ps
module sim_gated_pow2_prescaler;
  localparam int DG   = 16;
  localparam int WARM = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code = 4'd2;
  logic       oe_pin = 1'b1, pwr_pin = 1'b1, drive_low = 1'b0;
  logic       clk_out, pad_oe, ready;
  int         n_chk = 0, n_bad = 0;

  gated_pow2_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .presc_code(code), .oe_pin(oe_pin),
    .pwr_pin(pwr_pin), .drive_low(drive_low),
    .clk_out(clk_out), .pad_oe(pad_oe), .ready(ready)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Measures high width and full period from the next rising edge.
  task automatic measure(output int hi, output int per);
    int g = 0;
    int lo = 0;
    hi = 0;
    while (clk_out && g < 3000) begin step(); g++; end
    while (!clk_out && g < 3000) begin step(); g++; end
    while (clk_out && g < 3000) begin hi++; step(); g++; end
    while (!clk_out && g < 3000) begin lo++; step(); g++; end
    per = hi + lo;
  endtask

  task automatic t_reset();
    int seen_hi = 0;
    rst_n = 1'b0;
    step(5);
    chk(clk_out == 1'b0, "R3 reset clk_out", clk_out, 0);
    chk(ready == 1'b0, "R3 reset ready", ready, 0);
    chk(pad_oe == 1'b1, "R7 reset pad_oe", pad_oe, 1);
    rst_n = 1'b1;
    for (int i = 1; i <= WARM; i++) begin
      step();
      if (i < WARM && clk_out) seen_hi++;
      if (i == WARM - 1) chk(ready == 1'b0, "R3 ready before count", ready, 0);
      if (i == WARM)     chk(ready == 1'b1, "R3 ready after count", ready, 1);
    end
    chk(seen_hi == 0, "R3 output quiet in start-up", seen_hi, 0);
  endtask

  task automatic t_ratio(input logic [3:0] c, input int e, input string req);
    int hi, per;
    code = c;
    measure(hi, per);
    measure(hi, per);
    chk(hi == (1 << e), {req, " high"}, hi, 1 << e);
    chk(per == (2 << e), {req, " period"}, per, 2 << e);
  endtask

  task automatic t_change();
    int hi, per;
    code = 4'd2;
    measure(hi, per);
    measure(hi, per);
    // now in the first high cycle of a period
    code = 4'd5;
    measure(hi, per);
    chk(per == 64, "R9 first period after change", per, 64);
    chk(hi == 32, "R5 first pulse after change", hi, 32);
  endtask

  task automatic t_oe();
    int leak = 0;
    int hi, per;
    code = 4'd2;
    step(20);
    oe_pin = 1'b0;
    step(12);
    for (int i = 0; i < 40; i++) begin
      step();
      if (clk_out || !ready || !pad_oe) leak++;
    end
    chk(leak == 0, "R4 gated quiet with ready and pad", leak, 0);
    oe_pin = 1'b1;
    measure(hi, per);
    chk(hi == 4, "R5 first pulse after enable", hi, 4);
    chk(per == 8, "R4 ratio after enable", per, 8);
  endtask

  task automatic t_glitch();
    int drop = 0;
    int hi, per;
    pwr_pin = 1'b0;
    for (int i = 0; i < DG - 4; i++) begin step(); if (!ready) drop++; end
    pwr_pin = 1'b1;
    for (int i = 0; i < 30; i++) begin step(); if (!ready) drop++; end
    chk(drop == 0, "R6 short low ignored", drop, 0);
    measure(hi, per);
    chk(per == 8, "R6 period after short low", per, 8);
  endtask

  task automatic t_pd(input logic mode);
    drive_low = mode;
    pwr_pin = 1'b0;
    step(DG + 40);
    chk(ready == 1'b0, "R6 ready in power-down", ready, 0);
    chk(clk_out == 1'b0, "R6 output in power-down", clk_out, 0);
    chk(pad_oe == mode, "R7 pad_oe follows mode", pad_oe, mode);
    drive_low = ~mode;
    step();
    chk(pad_oe == !mode, "R7 pad_oe follows mode change", pad_oe, !mode);
    drive_low = mode;
  endtask

  task automatic t_wake(input logic [3:0] c, input int e);
    int found = 0;
    int expv = 3 + WARM + ((e == 0) ? 3 : (1 << e));
    code = c;
    pwr_pin = 1'b1;
    for (int i = 1; i <= WARM + 300 && found == 0; i++) begin
      step();
      if (i == WARM + 2) chk(ready == 1'b0, "R3 wake ready early", ready, 0);
      if (i == WARM + 3) chk(ready == 1'b1, "R3 wake ready", ready, 1);
      if (clk_out) found = i;
    end
    chk(found == expv, "R8 wake latency", found, expv);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ratio(4'd2, 2, "R1 x2");
    t_ratio(4'd0, 0, "R1 x0");
    t_ratio(4'd1, 1, "R1 x1");
    t_ratio(4'd8, 8, "R1 x8");
    t_ratio(4'd9, 8, "R2 code9");
    t_ratio(4'd15, 8, "R2 code15");
    t_ratio(4'd3, 3, "R1 x3");
    t_change();
    t_oe();
    t_glitch();
    t_pd(1'b1);
    t_wake(4'd2, 2);
    code = 4'd2;
    step(20);
    t_pd(1'b0);
    t_wake(4'd0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule